// File: doc/BRIEF.md
# Asynchronous DRAM Refresh Sequencer

This block keeps asynchronous DRAM contents alive by issuing refresh cycles at a programmable rate. A free-running down-counter, clocked by the bus clock, raises a refresh request each time a programmed interval runs out. When the access arbiter reports that the bus is free, a small state machine drives a CAS-before-RAS strobe pattern. It then holds the DRAM busy through a programmable precharge gap, and only after that gap may normal accesses resume.

Software sets the block up through one 16-bit control word. The word holds four fields:

- the refresh interval,
- the RAS-active length,
- the RAS-precharge length,
- a mode bit that selects synchronous DRAM.

The mode bit can only be set once, and only reset clears it again. While the mode bit is set, the sequencer stays silent. The word also stores a plain address-multiplexing option bit, which the block keeps but does not act on. Address multiplexing, the data path and synchronous command generation are handled elsewhere.

Top module: `dram_refresh_seq`

## Requirements
- R1: After reset, the control word reads 0x0000, both strobes are high, and the request and busy outputs are low.
- R2: A write stores bit 15 (mode), bit 13 (no-mux option), bits 12:11 (RAS code), bits 10:9 (precharge code) and bits 8:0 (interval). A read returns these fields at the same positions, and bit 14 always reads 0.
- R3: With mode 0, successive rising edges of the request are (interval + 1) * 16 clocks apart. An interval of 38 gives 624 clocks.
- R4: During a refresh, RAS is held low for (RAS code + 2) clocks.
- R5: After RAS rises, busy stays high for (precharge code + 1) clocks with both strobes high, and then falls.
- R6: CAS falls exactly one clock before RAS. Both strobes rise together, and the strobes are only low while busy is high.
- R7: While the bus is busy, a pending request is held and no refresh starts. The refresh starts, with busy high and CAS low, in the first cycle after the bus is sampled idle.
- R8: Once bit 15 is set, a write of 0 does not clear it. Only reset clears it.
- R9: While bit 15 is 1, no request rises and no refresh is started.
- R10: The interval restarts when the request is raised, so a delayed refresh does not shift the next request.
- R11: A new interval value takes effect only at the next reload. The interval that is already running completes with the old value. The first interval after reset uses interval 0, which gives 16 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Control word write enable |
| cfg_wdata_i | input | 16 | Control word write data |
| cfg_rdata_o | output | 16 | Stored control word, bit 14 reads zero |
| bus_busy_i | input | 1 | Arbiter reports an access in progress |
| ref_req_o | output | 1 | Refresh pending |
| ref_busy_o | output | 1 | Refresh sequence or precharge active; no access allowed |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |

## Verification
The strobe timing is exercised with the RAS and precharge codes at both extremes and with mixed pairs. The mixed pairs show whether the two fields are decoded independently or swapped. The interval is tried at the slow 624-clock setting and at the shortest 16-clock setting, with rewrites made in the middle of an interval. These rewrites separate a reload taken at the request from one taken at the end of the refresh. A stretch with the bus held busy checks that the request is held, that the start follows the release by exactly one cycle, and that the next request does not drift. Writing the mode bit, then clearing it, then resetting, checks that the bit is sticky and that the block stays silent while it is set.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;
  localparam int unsigned REG_W      = 16;
  localparam int unsigned IVL_W      = 9;
  localparam int unsigned SCALE_LOG2 = 4;
  localparam int unsigned CODE_W     = 2;
  localparam int unsigned RAS_MIN    = 2;
  localparam int unsigned PRE_MIN    = 1;

  // field positions are fixed by the read port decode
  localparam int unsigned BIT_SYNC  = 15;
  localparam int unsigned BIT_NOMUX = 13;
  localparam int unsigned RAS_LSB   = 11;
  localparam int unsigned PRE_LSB   = 9;
  localparam int unsigned IVL_LSB   = 0;

  typedef struct packed {
    logic              sync_sel;
    logic              no_mux;
    logic [CODE_W-1:0] ras_code;
    logic [CODE_W-1:0] pre_code;
    logic [IVL_W-1:0]  ivl;
  } ref_cfg_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CAS  = 2'd1,
    ST_RAS  = 2'd2,
    ST_PRE  = 2'd3
  } ref_state_e;
endpackage

// File: rtl/ref_cfg_reg.sv
module ref_cfg_reg
  import dram_ref_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  output ref_cfg_t         cfg_o,
  output logic [REG_W-1:0] rdata_o
);
  ref_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (we_i) begin
      cfg_q.sync_sel <= cfg_q.sync_sel | wdata_i[BIT_SYNC];  // sticky until reset
      cfg_q.no_mux   <= wdata_i[BIT_NOMUX];
      cfg_q.ras_code <= wdata_i[RAS_LSB +: CODE_W];
      cfg_q.pre_code <= wdata_i[PRE_LSB +: CODE_W];
      cfg_q.ivl      <= wdata_i[IVL_LSB +: IVL_W];
    end
  end

  always_comb begin
    rdata_o                         = '0;
    rdata_o[BIT_SYNC]               = cfg_q.sync_sel;
    rdata_o[BIT_NOMUX]              = cfg_q.no_mux;
    rdata_o[RAS_LSB +: CODE_W]      = cfg_q.ras_code;
    rdata_o[PRE_LSB +: CODE_W]      = cfg_q.pre_code;
    rdata_o[IVL_LSB +: IVL_W]       = cfg_q.ivl;
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/ref_interval_timer.sv
module ref_interval_timer #(
  parameter int unsigned IVL_W      = 9,
  parameter int unsigned SCALE_LOG2 = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [IVL_W-1:0] ivl_i,
  output logic             expire_o
);
  localparam int unsigned CNT_W = IVL_W + SCALE_LOG2;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] reload;

  // (ivl + 1) * 2^SCALE_LOG2 - 1
  assign reload   = {ivl_i, {SCALE_LOG2{1'b1}}};
  assign expire_o = run_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= {{IVL_W{1'b0}}, {SCALE_LOG2{1'b1}}};
    end else if (!run_i || cnt_q == '0) begin
      cnt_q <= reload;  // reload at request, not at refresh end
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/ref_seq_fsm.sv
module ref_seq_fsm
  import dram_ref_pkg::*;
#(
  parameter int unsigned CW      = CODE_W,
  parameter int unsigned RAS_LEN = RAS_MIN,
  parameter int unsigned PRE_LEN = PRE_MIN
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          enable_i,
  input  logic          expire_i,
  input  logic          bus_busy_i,
  input  logic [CW-1:0] ras_code_i,
  input  logic [CW-1:0] pre_code_i,
  output logic          req_o,
  output logic          busy_o,
  output logic          ras_n_o,
  output logic          cas_n_o
);
  localparam int unsigned MAX_LEN = RAS_LEN + (1 << CW);
  localparam int unsigned STEP_W  = $clog2(MAX_LEN);

  ref_state_e        state_q;
  logic              pend_q;
  logic [CW-1:0]     ras_code_q, pre_code_q;
  logic [STEP_W-1:0] step_q;
  logic              start;

  assign start = enable_i && pend_q && !bus_busy_i && (state_q == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          pend_q <= 1'b0;
    else if (!enable_i)   pend_q <= 1'b0;
    else if (start)       pend_q <= expire_i;
    else if (expire_i)    pend_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      step_q     <= '0;
      ras_code_q <= '0;
      pre_code_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start) begin
          state_q    <= ST_CAS;
          ras_code_q <= ras_code_i;  // lengths frozen for this refresh
          pre_code_q <= pre_code_i;
        end
        ST_CAS: begin
          state_q <= ST_RAS;
          step_q  <= STEP_W'(RAS_LEN - 1) + STEP_W'(ras_code_q);
        end
        ST_RAS: if (step_q == '0) begin
          state_q <= ST_PRE;
          step_q  <= STEP_W'(PRE_LEN - 1) + STEP_W'(pre_code_q);
        end else begin
          step_q <= step_q - 1'b1;
        end
        ST_PRE: if (step_q == '0) state_q <= ST_IDLE;
                else              step_q  <= step_q - 1'b1;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_o   = pend_q;
  assign busy_o  = (state_q != ST_IDLE);
  assign cas_n_o = !((state_q == ST_CAS) || (state_q == ST_RAS));
  assign ras_n_o = !(state_q == ST_RAS);
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import dram_ref_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [REG_W-1:0] cfg_wdata_i,
  output logic [REG_W-1:0] cfg_rdata_o,
  input  logic             bus_busy_i,
  output logic             ref_req_o,
  output logic             ref_busy_o,
  output logic             ras_n_o,
  output logic             cas_n_o
);
  ref_cfg_t cfg;
  logic     expire;

  ref_cfg_reg i_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .cfg_o   (cfg),
    .rdata_o (cfg_rdata_o)
  );

  ref_interval_timer #(
    .IVL_W      (IVL_W),
    .SCALE_LOG2 (SCALE_LOG2)
  ) i_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (!cfg.sync_sel),
    .ivl_i    (cfg.ivl),
    .expire_o (expire)
  );

  ref_seq_fsm #(
    .CW      (CODE_W),
    .RAS_LEN (RAS_MIN),
    .PRE_LEN (PRE_MIN)
  ) i_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .enable_i   (!cfg.sync_sel),
    .expire_i   (expire),
    .bus_busy_i (bus_busy_i),
    .ras_code_i (cfg.ras_code),
    .pre_code_i (cfg.pre_code),
    .req_o      (ref_req_o),
    .busy_o     (ref_busy_o),
    .ras_n_o    (ras_n_o),
    .cas_n_o    (cas_n_o)
  );
endmodule

// File: rtl/dram_refresh_seq_chk.sv
module dram_refresh_seq_chk
  import dram_ref_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic [REG_W-1:0] cfg_rdata_o,
  input logic             bus_busy_i,
  input logic             ref_req_o,
  input logic             ref_busy_o,
  input logic             ras_n_o,
  input logic             cas_n_o
);
  assert_cas_leads_ras_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n_o) |-> (!cas_n_o && !$past(cas_n_o)));

  assert_strobes_rise_together_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ras_n_o) |-> cas_n_o);

  assert_strobes_inside_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ras_n_o || !cas_n_o) |-> ref_busy_o);

  assert_ras_min_len_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n_o) |=> !ras_n_o);

  assert_precharge_held_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ras_n_o) |-> ref_busy_o);

  assert_start_on_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ref_busy_o) |-> ($past(ref_req_o) && !$past(bus_busy_i)));

  assert_sync_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_rdata_o[BIT_SYNC] |=> cfg_rdata_o[BIT_SYNC]);

  assert_no_req_in_sync_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_rdata_o[BIT_SYNC] |=> !$rose(ref_req_o));
endmodule

bind dram_refresh_seq dram_refresh_seq_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_rdata_o (cfg_rdata_o),
  .bus_busy_i  (bus_busy_i),
  .ref_req_o   (ref_req_o),
  .ref_busy_o  (ref_busy_o),
  .ras_n_o     (ras_n_o),
  .cas_n_o     (cas_n_o)
);

// File: tb/test_dram_refresh_seq.sv
module test_dram_refresh_seq;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        bus_busy = 1'b0;
  logic        ref_req, ref_busy, ras_n, cas_n;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dram_refresh_seq i_dram_refresh_seq (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .cfg_we_i    (cfg_we),
    .cfg_wdata_i (cfg_wdata),
    .cfg_rdata_o (cfg_rdata),
    .bus_busy_i  (bus_busy),
    .ref_req_o   (ref_req),
    .ref_busy_o  (ref_busy),
    .ras_n_o     (ras_n),
    .cas_n_o     (cas_n)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // request rise logger
  int   rise_cnt = 0;
  int   rise_t[$];
  logic req_d = 1'b0;
  always @(negedge clk) begin
    if (ref_req === 1'b1 && req_d !== 1'b1) begin
      rise_cnt++;
      rise_t.push_back(cyc);
    end
    req_d = ref_req;
  end

  // scoreboard
  typedef struct { int ras_len; int pre_len; } ref_item_t;
  ref_item_t exp_q[$];
  bit sb_on = 1'b0;
  int m_cas, m_ras, m_pre, m_bad;
  bit in_ref = 1'b0;

  always @(negedge clk) begin
    if (ref_busy === 1'b1) begin
      if (!in_ref) begin
        in_ref = 1'b1; m_cas = 0; m_ras = 0; m_pre = 0; m_bad = 0;
      end
      case ({ras_n, cas_n})
        2'b10:   begin m_cas++; if (m_ras != 0) m_bad++; end
        2'b00:   begin m_ras++; if (m_pre != 0) m_bad++; end
        2'b11:   begin m_pre++; if (m_ras == 0) m_bad++; end
        default: m_bad++;
      endcase
    end else if (in_ref) begin
      in_ref = 1'b0;
      if (sb_on) begin
        if (exp_q.size() == 0) begin
          check("R6", 1, 0, "refresh with no expected item");
        end else begin
          ref_item_t it;
          it = exp_q.pop_front();
          check("R6", m_cas, 1, "CAS lead cycles");
          check("R6", m_bad, 0, "strobe order faults");
          check("R4", m_ras, it.ras_len, "RAS low cycles");
          check("R5", m_pre, it.pre_len, "precharge cycles");
        end
      end
    end
  end

  task automatic expect_refreshes(int n, int rcode, int pcode);
    for (int i = 0; i < n; i++) begin
      ref_item_t it;
      it.ras_len = rcode + 2;
      it.pre_len = pcode + 1;
      exp_q.push_back(it);
    end
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic reg_write(logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_rises(int n);
    while (rise_cnt < n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d cycles", WATCHDOG, 0);
    finish_run();
  end

  initial begin
    int rst_cyc, n0, n1, viol;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    rst_cyc = cyc;
    // R1 reset state
    check("R1", cfg_rdata, 16'h0000, "control word");
    check("R1", {ras_n, cas_n}, 2'b11, "strobes");
    check("R1", {ref_req, ref_busy}, 2'b00, "req/busy");

    // R2: bit14 written as 1 must read 0; no-mux bit kept
    sb_on = 1'b1;
    reg_write(16'h7226);
    check("R2", cfg_rdata, 16'h3226, "read back");

    expect_refreshes(3, 2, 1);
    check("R11", rise_t[0] - rst_cyc, 16, "first interval uses reset value");
    check("R3", rise_t[1] - rise_t[0], 624, "interval 38");
    check("R3", rise_t[2] - rise_t[1], 624, "interval 38 repeat");

    // R11: new interval only after running one completes
    reg_write(16'h1200);
    expect_refreshes(2, 2, 1);
    check("R11", rise_t[3] - rise_t[2], 624, "running interval kept");
    check("R11", rise_t[4] - rise_t[3], 16, "new interval after reload");
    check("R3", rise_t[4] - rise_t[3], 16, "interval 0");

    // R4/R5 code sweep
    begin
      int rc[4] = '{0, 3, 1, 3};
      int pc[4] = '{0, 3, 2, 0};
      for (int k = 0; k < 4; k++) begin
        reg_write({3'b000, rc[k][1:0], pc[k][1:0], 9'd0});
        expect_refreshes(2, rc[k], pc[k]);
      end
    end

    // R7/R10: hold off with bus busy
    sb_on = 1'b0;
    reg_write(16'h0000);
    do @(negedge clk); while (ref_req || ref_busy);
    bus_busy = 1'b1;
    n0 = rise_cnt;
    wait_rises(n0 + 1);
    viol = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (ref_busy !== 1'b0 || ref_req !== 1'b1 || ras_n !== 1'b1 || cas_n !== 1'b1) viol++;
    end
    check("R7", viol, 0, "cycles with refresh activity while bus busy");
    bus_busy = 1'b0;
    check("R7", ref_busy, 0, "busy before idle sampled");
    @(negedge clk);
    check("R7", {ref_busy, cas_n, ras_n}, 3'b101, "start one cycle after idle");
    wait_rises(n0 + 2);
    check("R10", rise_t[n0 + 1] - rise_t[n0], 16, "no drift after delayed refresh");

    // R8/R9 sticky mode bit
    reg_write(16'h8000);
    check("R8", cfg_rdata[15], 1, "mode bit set");
    reg_write(16'h0000);
    check("R8", cfg_rdata, 16'h8000, "mode bit not cleared by write");
    repeat (12) @(negedge clk);
    n1 = rise_cnt;
    viol = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (ref_req !== 1'b0 || ref_busy !== 1'b0) viol++;
    end
    check("R9", viol, 0, "activity cycles in sync mode");
    check("R9", rise_cnt, n1, "request rises in sync mode");

    @(negedge clk);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    check("R8", cfg_rdata, 16'h0000, "mode bit cleared by reset");
    finish_run();
  end
endmodule